// File: doc/BRIEF.md
# Token-Firing Dataflow Processing Element

This block is one compute node of a spatial dataflow fabric. It owns two operand channels and one result channel. Each operand channel lands in its own small queue, so tokens arriving early on one side simply wait. Whenever both queues hold a token, a program is loaded and the result queue has space, the node fires. Firing takes the oldest token from each side, applies the single operation the node holds, and enqueues the result with a token. There is no program counter: availability of data alone decides when work happens.

The operation is chosen at run time through a broadcast configuration bus shared by many nodes. Each node has a fixed address set by a parameter. It takes a broadcast word only when the word's address field names it. Once programmed, the node accepts a new operation only while it holds no tokens anywhere, so a pending pair is never computed under a changed opcode.

Top module: `dataflow_pe`

## Requirements
- R1: While reset is held, `res_valid` is 0 and both `opa_ready` and `opb_ready` are 1, and no operation is loaded.
- R2: Before any operation has been loaded, operand tokens are queued but no result is produced.
- R3: A broadcast word is taken only when `cfg_valid` is 1 and its upper `ADDR_W` bits equal `NODE_ADDR`; the low 3 bits carry the opcode. A word for any other address changes nothing.
- R4: Opcode encodings: 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 unsigned a less than b, 6 equal, 7 yields 0; all arithmetic wraps modulo 2^DATA_W, and comparisons give 1 or 0.
- R5: Each firing consumes exactly one token from each operand queue; the k-th result is computed from the k-th a token and the k-th b token.
- R6: Each operand queue holds `IN_DEPTH` (default 4) tokens; its ready is 0 while it is full.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` stays unchanged; the node does not fire into a full result queue, so no result is lost.
- R8: Once loaded, a matching broadcast replaces the opcode only while all three queues are empty; otherwise it is ignored.
- R9: Tokens on one channel wait, without producing results, until the other channel supplies their partners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Broadcast word present |
| cfg_word | input | ADDR_W+3 | Broadcast word: {address, opcode} |
| opa_valid | input | 1 | Operand a token offered |
| opa_data | input | DATA_W | Operand a value |
| opa_ready | output | 1 | Operand a queue has room |
| opb_valid | input | 1 | Operand b token offered |
| opb_data | input | DATA_W | Operand b value |
| opb_ready | output | 1 | Operand b queue has room |
| res_valid | output | 1 | Result token available |
| res_data | output | DATA_W | Result value |
| res_ready | input | 1 | Downstream takes the result |

## Verification
The assertions take for granted that upstream senders hold `opa_data`/`opb_data` steady while valid waits on ready, and that configuration words come as single-cycle pulses. The assertions also rely on the internal reset being the only reset, so the FIFO levels start from zero. The stimulus drives every input at the falling edge and changes data only after a completed transfer. It pulses `cfg_valid` for one cycle at a time and issues broadcasts both to foreign addresses and to the node's own address while tokens are still pending.

// File: rtl/dfpe_pkg.sv
package dfpe_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_LTU = 3'd5,
    OP_EQ  = 3'd6,
    OP_NUL = 3'd7
  } pe_op_e;
endpackage

// File: rtl/dfpe_rst_sync.sv
module dfpe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dfpe_fifo.sv
module dfpe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_q] <= din;
  end

  assign dout  = slot[rd_q];
  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign level = cnt_q;
endmodule

// File: rtl/dfpe_alu.sv
module dfpe_alu
  import dfpe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pe_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LTU:  y = {{(DATA_W-1){1'b0}}, (a < b)};
      OP_EQ:   y = {{(DATA_W-1){1'b0}}, (a == b)};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dfpe_cfg.sv
module dfpe_cfg
  import dfpe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] NODE_ADDR = 'h2A,
  localparam int WORD_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              idle,
  output logic              loaded,
  output pe_op_e            op
);
  logic   loaded_d;
  pe_op_e op_d;
  logic   hit;
  logic   take;

  always_comb begin
    hit      = cfg_valid && (cfg_word[WORD_W-1:OP_W] == NODE_ADDR);
    take     = hit && (!loaded || idle);
    loaded_d = loaded || take;
    op_d     = take ? pe_op_e'(cfg_word[OP_W-1:0]) : op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      op     <= OP_ADD;
    end else begin
      loaded <= loaded_d;
      if (take) op <= op_d;
    end
  end
endmodule

// File: rtl/dataflow_pe.sv
module dataflow_pe
  import dfpe_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] NODE_ADDR = 'h2A,
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 2,
  localparam int WORD_W   = ADDR_W + OP_W,
  localparam int IN_LW    = $clog2(IN_DEPTH + 1),
  localparam int OUT_LW   = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              opa_valid,
  input  logic [DATA_W-1:0] opa_data,
  output logic              opa_ready,
  input  logic              opb_valid,
  input  logic [DATA_W-1:0] opb_data,
  output logic              opb_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  input  logic              res_ready
);
  logic rst_q_n;

  logic a_push, a_full, a_empty;
  logic b_push, b_full, b_empty;
  logic o_full, o_empty, o_pop;
  logic [DATA_W-1:0] a_head, b_head, alu_y;
  logic [IN_LW-1:0]  a_level, b_level;
  logic [OUT_LW-1:0] o_level;

  logic   loaded, idle, fire;
  pe_op_e cur_op;

  dfpe_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q_n)
  );

  dfpe_cfg #(.ADDR_W(ADDR_W), .NODE_ADDR(NODE_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .idle(idle), .loaded(loaded), .op(cur_op)
  );

  dfpe_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_qa (
    .clk(clk), .rst_n(rst_q_n), .push(a_push), .din(opa_data), .pop(fire),
    .dout(a_head), .full(a_full), .empty(a_empty), .level(a_level)
  );

  dfpe_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_qb (
    .clk(clk), .rst_n(rst_q_n), .push(b_push), .din(opb_data), .pop(fire),
    .dout(b_head), .full(b_full), .empty(b_empty), .level(b_level)
  );

  dfpe_alu #(.DATA_W(DATA_W)) u_alu (
    .op(cur_op), .a(a_head), .b(b_head), .y(alu_y)
  );

  dfpe_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_qo (
    .clk(clk), .rst_n(rst_q_n), .push(fire), .din(alu_y), .pop(o_pop),
    .dout(res_data), .full(o_full), .empty(o_empty), .level(o_level)
  );

  always_comb begin
    opa_ready = !a_full;
    opb_ready = !b_full;
    a_push    = opa_valid && opa_ready;
    b_push    = opb_valid && opb_ready;
    fire      = loaded && !a_empty && !b_empty && !o_full;
    res_valid = !o_empty;
    o_pop     = res_valid && res_ready;
    idle      = a_empty && b_empty && o_empty;
  end
endmodule

// File: rtl/dataflow_pe_chk.sv
module dataflow_pe_chk
  import dfpe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] NODE_ADDR = 'h2A,
  parameter int IN_DEPTH = 4,
  localparam int WORD_W = ADDR_W + OP_W,
  localparam int IN_LW  = $clog2(IN_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              cfg_valid,
  input logic [WORD_W-1:0] cfg_word,
  input logic              loaded,
  input pe_op_e            cur_op,
  input logic              idle,
  input logic              fire,
  input logic              a_push,
  input logic [IN_LW-1:0]  a_level,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);
  // R2
  unloaded_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !loaded |-> !fire);

  // R3
  foreign_cfg_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_valid && cfg_word[WORD_W-1:OP_W] != NODE_ADDR) |=> ($stable(cur_op) && $stable(loaded)));

  // R5
  one_token_pop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && !a_push) |=> (a_level == IN_LW'($past(a_level) - 1'b1)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    a_level <= IN_LW'(IN_DEPTH));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R8
  busy_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (loaded && !idle) |=> $stable(cur_op));
endmodule

bind dataflow_pe dataflow_pe_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NODE_ADDR(NODE_ADDR), .IN_DEPTH(IN_DEPTH)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
  .loaded(loaded), .cur_op(cur_op), .idle(idle), .fire(fire), .a_push(a_push),
  .a_level(a_level), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/dataflow_pe_bench.sv
`timescale 1ns/1ps
module dataflow_pe_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] ME = 8'h2A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_valid;
  logic [AW+2:0] cfg_word;
  logic          opa_valid, opa_ready, opb_valid, opb_ready;
  logic [DW-1:0] opa_data, opb_data, res_data;
  logic          res_valid, res_ready;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R5";
  logic [DW-1:0] exp_q[$];
  logic [2:0] model_op;
  bit done = 0;

  always #2.5 clk = ~clk;

  dataflow_pe #(.DATA_W(DW), .ADDR_W(AW), .NODE_ADDR(ME)) u_dataflow_pe (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .opa_valid(opa_valid), .opa_data(opa_data), .opa_ready(opa_ready),
    .opb_valid(opb_valid), .opb_data(opb_data), .opb_ready(opb_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready)
  );

  function automatic logic [DW-1:0] model(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return (a < b) ? 1 : 0;
      3'd6: return (a == b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted result
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s: actual %h expected none (unexpected result)", cur_req, res_data);
      end else begin
        check(cur_req, res_data, exp_q.pop_front());
      end
    end
  end

  task automatic push_a(logic [DW-1:0] d);
    @(negedge clk); opa_valid = 1'b1; opa_data = d;
    while (!opa_ready) @(negedge clk);
    @(negedge clk); opa_valid = 1'b0;
  endtask

  task automatic push_b(logic [DW-1:0] d);
    @(negedge clk); opb_valid = 1'b1; opb_data = d;
    while (!opb_ready) @(negedge clk);
    @(negedge clk); opb_valid = 1'b0;
  endtask

  task automatic broadcast(logic [AW-1:0] addr, logic [2:0] op);
    @(negedge clk); cfg_valid = 1'b1; cfg_word = {addr, op};
    @(negedge clk); cfg_valid = 1'b0;
  endtask

  task automatic pair(logic [DW-1:0] a, logic [DW-1:0] b);
    exp_q.push_back(model(model_op, a, b));
    push_a(a);
    push_b(b);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_word = '0;
    opa_valid = 1'b0; opa_data = '0; opb_valid = 1'b0; opb_data = '0;
    res_ready = 1'b1; model_op = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'b0, res_valid}, 0);
    check("R1", {31'b0, opa_ready}, 1);
    check("R1", {31'b0, opb_ready}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: four a tokens fill the queue (unloaded node never drains it)
    for (int i = 0; i < 4; i++) push_a(32'h100 + i);
    check("R6", {31'b0, opa_ready}, 0);
    for (int i = 0; i < 4; i++) push_b(32'h10 * i);
    repeat (4) @(negedge clk);
    // R2 no result before load
    check("R2", {31'b0, res_valid}, 0);
    // R3 foreign address ignored
    broadcast(8'h15, 3'd0);
    repeat (4) @(negedge clk);
    check("R3", {31'b0, res_valid}, 0);
    // own address loads ADD; queued tokens pair in order (R5)
    cur_req = "R5";
    for (int i = 0; i < 4; i++) exp_q.push_back(32'h100 + i + 32'h10 * i);
    model_op = 3'd0;
    broadcast(ME, 3'd0);
    drain();

    // R4 every opcode with corner values
    cur_req = "R4";
    pair(32'hFFFF_FFFF, 32'h1);
    drain();
    model_op = 3'd1; broadcast(ME, 3'd1);
    pair(32'h0, 32'h1); pair(32'h50, 32'h8);
    drain();
    model_op = 3'd2; broadcast(ME, 3'd2);
    pair(32'hF0F0_1234, 32'h0FF0_FF00);
    drain();
    model_op = 3'd3; broadcast(ME, 3'd3);
    pair(32'hA000_0005, 32'h0000_0500);
    drain();
    model_op = 3'd5; broadcast(ME, 3'd5);
    pair(32'd5, 32'd7); pair(32'd7, 32'd5); pair(32'hFFFF_FFFF, 32'd1); pair(32'd9, 32'd9);
    drain();
    model_op = 3'd6; broadcast(ME, 3'd6);
    pair(32'd9, 32'd9); pair(32'd9, 32'd8);
    drain();
    model_op = 3'd7; broadcast(ME, 3'd7);
    pair(32'h1234, 32'h5678);
    drain();

    // R9 b arrives first and waits for a
    cur_req = "R9";
    model_op = 3'd1; broadcast(ME, 3'd1);
    for (int i = 0; i < 3; i++) exp_q.push_back(model(3'd1, 32'h1000 * (i + 1), 32'd3 + i));
    for (int i = 0; i < 3; i++) push_b(32'd3 + i);
    repeat (4) @(negedge clk);
    check("R9", {31'b0, res_valid}, 0);
    for (int i = 0; i < 3; i++) push_a(32'h1000 * (i + 1));
    drain();

    // R7 stall holds output, R8 reconfiguration while busy ignored
    cur_req = "R8";
    model_op = 3'd4; broadcast(ME, 3'd4);
    res_ready = 1'b0;
    for (int i = 0; i < 4; i++) pair(32'hAAAA_0000 + i, 32'h0000_5555 * (i + 1));
    repeat (3) @(negedge clk);
    check("R7", {31'b0, res_valid}, 1);
    held = res_data;
    broadcast(ME, 3'd2);
    repeat (5) @(negedge clk);
    check("R7", {31'b0, res_valid}, 1);
    check("R7", res_data, held);
    res_ready = 1'b1;
    drain();
    // node now idle: the same broadcast takes effect
    model_op = 3'd2; broadcast(ME, 3'd2);
    pair(32'hFF00_FF00, 32'h0F0F_0F0F);
    drain();

    done = 1;
    summary();
  end
endmodule